// File: doc/BRIEF.md
# Word-Interleaved Shared Memory Crossbar

This block lets several processor data ports share one level-one data memory built from independent single-port banks. Successive 32-bit words of the address space sit in successive banks, so cores walking through arrays in parallel tend to land on different banks and run without waiting. Each master raises a request together with its address, write flag, byte-lane mask and store data. It keeps all of them steady until it sees its grant in the same cycle.

Every bank has its own round-robin arbiter. A master that is alone on its bank is granted at once, and the access reaches the bank array on that clock edge. When two or more masters aim at one bank in the same cycle, exactly one of them wins. The rest see no grant and try again. Load data comes back one cycle after the grant, with a valid pulse. It is steered to the right master by a registered copy of the index of the master that won each bank.

Top module: `tcdm_xbar`

## Requirements
- R1: The bank index is address bits [log2(NB)+1:2]. The row inside the bank comes from the address bits above those. Words that differ in bank or row never alias.
- R2: A master whose request is the only one on its bank in a cycle is granted in that same cycle.
- R3: A granted load raises that master's valid output exactly one cycle later, with the addressed word on its data output. A granted store raises no valid. A master's valid never rises without a granted load one cycle earlier.
- R4: On a store, byte-mask bit i enables data bits [8i+7:8i]. Lanes whose mask bit is 0 keep their old contents.
- R5: Masters that target different banks in the same cycle are all granted in that cycle.
- R6: At most one master per bank is granted in a cycle. A stalled master has no effect on memory until it is granted.
- R7: Each bank's arbiter passes priority to the first requesting master after the one it granted last, in cyclic index order. Three masters that keep requesting are therefore served in a rotating order.
- R8: Reset clears all grants and valid outputs. Each arbiter's priority starts at master 0, so a contest right after reset is won by the lowest requesting index.
- R9: No grant is given to a master that is not requesting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| m_req_i | input | NM | Request per master |
| m_addr_i | input | NM*AW | Byte address per master |
| m_we_i | input | NM | Store (1) or load (0) per master |
| m_be_i | input | NM*DW/8 | Byte-lane mask per master |
| m_wdata_i | input | NM*DW | Store data per master |
| m_gnt_o | output | NM | Grant per master, same cycle as the request |
| m_rvalid_o | output | NM | Load response valid, one cycle after grant |
| m_rdata_o | output | NM*DW | Load data per master |

## Verification
Four properties hold on every cycle. No master is granted without a request. No two granted masters share a bank. A master alone on its bank is always granted. The valid output tracks granted loads with a lag of exactly one cycle. Three things follow only from the bench's scenarios. The first is the data itself: interleaved placement, byte-lane merging, and a stalled store landing only after its grant. The second is the rotating service order among persistent contenders. The third is the initial priority after reset.

// File: rtl/tcdm_xbar_pkg.sv
package tcdm_xbar_pkg;

  // word index of a byte address
  function automatic int unsigned word_of(input logic [31:0] a);
    return int'(a >> 2);
  endfunction

  // bank selected by a byte address with nb banks (nb a power of two)
  function automatic int unsigned bank_of(input logic [31:0] a, input int unsigned nb);
    return word_of(a) % nb;
  endfunction

  // row inside the bank: word index with the bank bits removed
  function automatic int unsigned row_of(input logic [31:0] a, input int unsigned nb);
    return word_of(a) / nb;
  endfunction

  // cyclic successor of the last winner
  function automatic int unsigned rr_next(input int unsigned w, input int unsigned n);
    return (w + 1 == n) ? 0 : w + 1;
  endfunction

endpackage

// File: rtl/tcdm_rr_arb.sv
module tcdm_rr_arb
  import tcdm_xbar_pkg::*;
#(
  parameter int N = 4,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [N-1:0]  req_i,
  output logic [N-1:0]  gnt_o,
  output logic [IW-1:0] win_o,
  output logic          any_o
);

  logic [IW-1:0] prio_q;

  always_comb begin
    int unsigned idx;
    gnt_o = '0;
    win_o = '0;
    any_o = 1'b0;
    idx   = 0;
    for (int unsigned i = 0; i < N; i++) begin
      idx = 32'(prio_q) + i;
      if (idx >= N) idx = idx - N;
      if (!any_o && req_i[idx]) begin
        any_o      = 1'b1;
        gnt_o[idx] = 1'b1;
        win_o      = IW'(idx);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    prio_q <= '0;
    else if (any_o) prio_q <= IW'(rr_next(32'(win_o), N));
  end

endmodule

// File: rtl/tcdm_bank.sv
module tcdm_bank #(
  parameter int DW   = 32,
  parameter int ROWS = 64,
  localparam int RW  = $clog2(ROWS),
  localparam int BEW = DW / 8
) (
  input  logic           clk_i,
  input  logic           en_i,
  input  logic           we_i,
  input  logic [BEW-1:0] be_i,
  input  logic [RW-1:0]  row_i,
  input  logic [DW-1:0]  wdata_i,
  output logic [DW-1:0]  rdata_o
);

  logic [DW-1:0] store [ROWS];

  always_ff @(posedge clk_i) begin
    if (en_i && we_i) begin
      for (int l = 0; l < BEW; l++)
        if (be_i[l]) store[row_i][8*l +: 8] <= wdata_i[8*l +: 8];
    end
    if (en_i && !we_i) rdata_o <= store[row_i];
  end

endmodule

// File: rtl/tcdm_xbar.sv
module tcdm_xbar
  import tcdm_xbar_pkg::*;
#(
  parameter int NM   = 4,
  parameter int NB   = 4,
  parameter int AW   = 12,
  parameter int DW   = 32,
  parameter int ROWS = 64,
  localparam int BEW = DW / 8,
  localparam int BW  = $clog2(NB),
  localparam int RW  = $clog2(ROWS),
  localparam int IW  = (NM > 1) ? $clog2(NM) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NM-1:0]     m_req_i,
  input  logic [NM*AW-1:0]  m_addr_i,
  input  logic [NM-1:0]     m_we_i,
  input  logic [NM*BEW-1:0] m_be_i,
  input  logic [NM*DW-1:0]  m_wdata_i,
  output logic [NM-1:0]     m_gnt_o,
  output logic [NM-1:0]     m_rvalid_o,
  output logic [NM*DW-1:0]  m_rdata_o
);

  // per-master decoded target
  logic [BW-1:0] tgt_bank [NM];
  logic [RW-1:0] tgt_row  [NM];
  // per-bank request, grant and winner
  logic [NM-1:0] bank_req [NB];
  logic [NM-1:0] bank_gnt [NB];
  logic [IW-1:0] bank_win [NB];
  logic [NB-1:0] bank_act;
  logic [DW-1:0] bank_rdata [NB];
  // response routing state
  logic [IW-1:0] resp_win_q [NB];
  logic [NB-1:0] resp_vld_q;

  always_comb begin
    for (int m = 0; m < NM; m++) begin
      tgt_bank[m] = BW'(bank_of(32'(m_addr_i[m*AW +: AW]), NB));
      tgt_row[m]  = RW'(row_of(32'(m_addr_i[m*AW +: AW]), NB));
    end
    for (int b = 0; b < NB; b++)
      for (int m = 0; m < NM; m++)
        bank_req[b][m] = m_req_i[m] && (tgt_bank[m] == BW'(b));
  end

  for (genvar b = 0; b < NB; b++) begin : g_bank
    logic           sel_we;
    logic [BEW-1:0] sel_be;
    logic [RW-1:0]  sel_row;
    logic [DW-1:0]  sel_wdata;

    tcdm_rr_arb #(.N(NM)) u_arb (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .req_i  (bank_req[b]),
      .gnt_o  (bank_gnt[b]),
      .win_o  (bank_win[b]),
      .any_o  (bank_act[b])
    );

    always_comb begin
      sel_we    = m_we_i[bank_win[b]];
      sel_be    = m_be_i[bank_win[b]*BEW +: BEW];
      sel_row   = tgt_row[bank_win[b]];
      sel_wdata = m_wdata_i[bank_win[b]*DW +: DW];
    end

    tcdm_bank #(.DW(DW), .ROWS(ROWS)) u_mem (
      .clk_i   (clk_i),
      .en_i    (bank_act[b]),
      .we_i    (sel_we),
      .be_i    (sel_be),
      .row_i   (sel_row),
      .wdata_i (sel_wdata),
      .rdata_o (bank_rdata[b])
    );

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        resp_vld_q[b] <= 1'b0;
        resp_win_q[b] <= '0;
      end else begin
        resp_vld_q[b] <= bank_act[b] && !sel_we;
        resp_win_q[b] <= bank_win[b];
      end
    end
  end

  always_comb begin
    m_gnt_o    = '0;
    m_rvalid_o = '0;
    m_rdata_o  = '0;
    for (int b = 0; b < NB; b++) begin
      m_gnt_o = m_gnt_o | bank_gnt[b];
      if (resp_vld_q[b]) begin
        m_rvalid_o[resp_win_q[b]]           = 1'b1;
        m_rdata_o[resp_win_q[b]*DW +: DW]   = bank_rdata[b];
      end
    end
  end

endmodule

// File: rtl/tcdm_xbar_checker.sv
module tcdm_xbar_checker
  import tcdm_xbar_pkg::*;
#(
  parameter int NM = 4,
  parameter int NB = 4,
  parameter int AW = 12
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [NM-1:0]    m_req_i,
  input logic [NM*AW-1:0] m_addr_i,
  input logic [NM-1:0]    m_we_i,
  input logic [NM-1:0]    m_gnt_o,
  input logic [NM-1:0]    m_rvalid_o
);

  int unsigned bk [NM];
  logic [NM-1:0] shared;

  always_comb begin
    for (int m = 0; m < NM; m++) bk[m] = bank_of(32'(m_addr_i[m*AW +: AW]), NB);
    for (int m = 0; m < NM; m++) begin
      shared[m] = 1'b0;
      for (int o = 0; o < NM; o++)
        if (o != m && m_req_i[o] && bk[o] == bk[m]) shared[m] = 1'b1;
    end
  end

  a_r9_gnt_needs_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (m_gnt_o & ~m_req_i) == '0) else $error("R9 grant without request");

  for (genvar m = 0; m < NM; m++) begin : g_m
    a_r2_lone_granted: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (m_req_i[m] && !shared[m]) |-> m_gnt_o[m]) else $error("R2 lone request stalled");

    a_r3_load_returns: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (m_gnt_o[m] && !m_we_i[m]) |=> m_rvalid_o[m]) else $error("R3 missing response");

    a_r3_no_spurious: assert property (@(posedge clk_i) disable iff (!rst_ni)
      m_rvalid_o[m] |-> $past(m_gnt_o[m] && !m_we_i[m])) else $error("R3 spurious valid");

    for (genvar o = m + 1; o < NM; o++) begin : g_o
      a_r6_bank_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (m_gnt_o[m] && m_gnt_o[o]) |-> (bk[m] != bk[o])) else $error("R6 double grant on bank");
    end
  end

endmodule

bind tcdm_xbar tcdm_xbar_checker #(.NM(NM), .NB(NB), .AW(AW)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .m_req_i    (m_req_i),
  .m_addr_i   (m_addr_i),
  .m_we_i     (m_we_i),
  .m_gnt_o    (m_gnt_o),
  .m_rvalid_o (m_rvalid_o)
);

// File: tb/tcdm_xbar_test.sv
`timescale 1ns/1ps
module tcdm_xbar_test;
  localparam int NM = 4, NB = 4, AW = 12, DW = 32, ROWS = 64, BEW = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [NM-1:0]     req = '0, we = '0;
  logic [NM*AW-1:0]  addr = '0;
  logic [NM*BEW-1:0] be = '0;
  logic [NM*DW-1:0]  wd = '0;
  logic [NM-1:0]     gnt, rvalid;
  logic [NM*DW-1:0]  rdata;
  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  tcdm_xbar #(.NM(NM), .NB(NB), .AW(AW), .DW(DW), .ROWS(ROWS)) uut (
    .clk_i(clk), .rst_ni(rst_n), .m_req_i(req), .m_addr_i(addr), .m_we_i(we),
    .m_be_i(be), .m_wdata_i(wd), .m_gnt_o(gnt), .m_rvalid_o(rvalid), .m_rdata_o(rdata));

  typedef struct packed {
    logic [1:0]  m;
    logic        st;
    logic [11:0] a;
    logic [3:0]  mask;
    logic [31:0] d;
    logic [31:0] ex;
  } vec_t;

  // bank = addr[3:2], row = addr[9:4]
  localparam vec_t VEC [11] = '{
    '{2'd0, 1'b1, 12'h000, 4'hF, 32'h11111111, 32'h0},        // R1 bank0 row0
    '{2'd1, 1'b1, 12'h004, 4'hF, 32'h22222222, 32'h0},        // R1 bank1 row0
    '{2'd2, 1'b0, 12'h000, 4'h0, 32'h0, 32'h11111111},        // R1 R3
    '{2'd3, 1'b0, 12'h004, 4'h0, 32'h0, 32'h22222222},        // R1 R3
    '{2'd1, 1'b1, 12'h000, 4'b0101, 32'hAABBCCDD, 32'h0},     // R4 partial
    '{2'd0, 1'b0, 12'h000, 4'h0, 32'h0, 32'h11BB11DD},        // R4 merged
    '{2'd2, 1'b1, 12'h018, 4'hF, 32'h5A5A5A5A, 32'h0},        // bank2 row1
    '{2'd3, 1'b0, 12'h018, 4'h0, 32'h0, 32'h5A5A5A5A},
    '{2'd0, 1'b1, 12'h010, 4'hF, 32'h0F0F0F0F, 32'h0},        // bank0 row1
    '{2'd1, 1'b0, 12'h000, 4'h0, 32'h0, 32'h11BB11DD},        // R1 no alias
    '{2'd3, 1'b1, 12'h02C, 4'hF, 32'h3C3C3C3C, 32'h0}         // bank3 row2
  };

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive(input int m, input logic st, input logic [11:0] a,
                       input logic [3:0] mask, input logic [31:0] d);
    req[m] = 1'b1; we[m] = st; addr[m*AW +: AW] = a;
    be[m*BEW +: BEW] = mask; wd[m*DW +: DW] = d;
  endtask

  task automatic do_reset();
    req = '0; we = '0;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(8 * 20000);
    check(0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    do_reset();
    #1;
    check(gnt == '0, "R8 gnt idle after reset", 32'(gnt), 0);
    check(rvalid == '0, "R8 rvalid idle after reset", 32'(rvalid), 0);

    // R8/R6: stalled store lands only when granted; priority starts at 0
    @(negedge clk);
    drive(0, 1'b1, 12'h020, 4'hF, 32'hAAAA0000);
    drive(3, 1'b1, 12'h020, 4'hF, 32'hBBBB3333);
    #1;
    check(gnt == 4'b0001, "R8 first winner is master0", 32'(gnt), 32'h1);
    @(negedge clk); req[0] = 1'b0; #1;
    check(gnt == 4'b1000, "R6 stalled master3 served next", 32'(gnt), 32'h8);
    @(negedge clk); req[3] = 1'b0;
    drive(1, 1'b0, 12'h020, 4'h0, 32'h0);
    @(negedge clk); req[1] = 1'b0;
    check(rvalid[1] && rdata[1*DW +: DW] == 32'hBBBB3333, "R6 later store wins",
          rdata[1*DW +: DW], 32'hBBBB3333);

    // table of single-master transactions
    for (int i = 0; i < 11; i++) begin
      @(negedge clk);
      drive(int'(VEC[i].m), VEC[i].st, VEC[i].a, VEC[i].mask, VEC[i].d);
      #1;
      check(gnt == (4'b1 << VEC[i].m), "R2 lone request granted", 32'(gnt), 32'(4'b1 << VEC[i].m));
      @(negedge clk); req = '0;
      if (VEC[i].st)
        check(rvalid == '0, "R3 store gives no valid", 32'(rvalid), 0);
      else begin
        check(rvalid == (4'b1 << VEC[i].m), "R3 valid one cycle later", 32'(rvalid), 32'(4'b1 << VEC[i].m));
        check(rdata[VEC[i].m*DW +: DW] == VEC[i].ex, "R1 R4 load data",
              rdata[VEC[i].m*DW +: DW], VEC[i].ex);
      end
    end

    // R5: four masters on four banks in one cycle
    @(negedge clk);
    drive(0, 1'b0, 12'h010, 4'h0, 0);
    drive(1, 1'b0, 12'h004, 4'h0, 0);
    drive(2, 1'b0, 12'h018, 4'h0, 0);
    drive(3, 1'b0, 12'h02C, 4'h0, 0);
    #1;
    check(gnt == 4'b1111, "R5 parallel grants", 32'(gnt), 32'hF);
    @(negedge clk); req = '0;
    check(rvalid == 4'b1111, "R5 R3 parallel valids", 32'(rvalid), 32'hF);
    check(rdata[0*DW +: DW] == 32'h0F0F0F0F, "R5 data m0", rdata[0*DW +: DW], 32'h0F0F0F0F);
    check(rdata[1*DW +: DW] == 32'h22222222, "R5 data m1", rdata[1*DW +: DW], 32'h22222222);
    check(rdata[2*DW +: DW] == 32'h5A5A5A5A, "R5 data m2", rdata[2*DW +: DW], 32'h5A5A5A5A);
    check(rdata[3*DW +: DW] == 32'h3C3C3C3C, "R5 data m3", rdata[3*DW +: DW], 32'h3C3C3C3C);

    // R7: masters 0, 2, 3 keep reading bank1; expect rotation 0,2,3,0,2,3
    do_reset();
    drive(0, 1'b0, 12'h004, 4'h0, 0);
    drive(2, 1'b0, 12'h014, 4'h0, 0);
    drive(3, 1'b0, 12'h024, 4'h0, 0);
    begin
      logic [3:0] order [3] = '{4'b0001, 4'b0100, 4'b1000};
      logic [3:0] prev = '0;
      for (int c = 0; c < 6; c++) begin
        #1;
        check(gnt == order[c % 3], "R7 rotating grant", 32'(gnt), 32'(order[c % 3]));
        if (c > 0) check(rvalid == prev, "R3 valid follows grant", 32'(rvalid), 32'(prev));
        prev = gnt;
        @(negedge clk);
      end
    end
    req = '0;
    #1;
    check(gnt == '0, "R9 no grant without request", 32'(gnt), 0);
    @(negedge clk);
    finish_run();
  end
endmodule